// File: doc/BRIEF.md
# Wait-State Memory Slave for an AHB-Lite Bus

This block is a bus slave that fronts a small word-organised register array. A transfer is split over two bus cycles. In the address cycle the slave captures the address, the direction and the size, provided it is selected, the transfer type is active and the system ready is high. In the following data cycle it commits the write data or presents the read word. Because the bus is pipelined, the data cycle of one transfer overlaps the address cycle of the next. The slave therefore keeps its captured controls in a register and does not reread them from the bus.

A parameter sets a fixed number of stall cycles for every transfer. During these cycles the slave's ready output is held low and the data cycle is stretched. When the parameter is zero, transfers run back to back with no stalls. The slave accepts a new address only on an edge where the system-wide ready is high. While it stalls, its captured controls stay frozen and the next address is not accepted. Writes may be byte, halfword or word wide and update only the byte lanes they cover. Reads always return the whole word.

Top module: `ahb_wait_mem`

## Requirements
- R1: After reset, HREADYOUT is 1, HRESP is 0 and HRDATA is 0, every memory word reads as 0, and HREADYOUT stays 1 whenever no transfer is in its data cycle.
- R2: An address cycle is captured only when HSEL is 1, HTRANS is 2'b10 (first transfer) or 2'b11 (follow-on transfer), and HREADY is 1. With HSEL at 0, or HTRANS at 2'b00 (idle) or 2'b01 (pause), memory is left unchanged.
- R3: A captured write stores HWDATA into word index HADDR[5:2] (16 words by default). The data is sampled on the first rising edge of its data cycle on which HREADY is 1.
- R4: In a read data cycle, HRDATA carries the addressed word and is valid on the cycle HREADYOUT is 1. Outside read data cycles, HRDATA is 0.
- R5: With WAIT_STATES = N > 0, each captured transfer drives HREADYOUT low for exactly N consecutive cycles, starting in the cycle after capture, and then drives it high.
- R6: With WAIT_STATES = 0, HREADYOUT never goes low. A write followed in the very next cycle by a read of the same word returns the newly written data.
- R7: HSIZE selects the write width: 0 = one byte at HADDR[1:0], 1 = a halfword at HADDR[1], 2 or more = the whole word. Bytes outside the selected lanes keep their old value.
- R8: HRESP is always 0 (OKAY).
- R9: While HREADY is low, no new address is captured and the controls already captured stay unchanged. A write that is presented while HREADY is low and withdrawn before HREADY rises has no effect. A write that is held until HREADY rises is performed exactly once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| HCLK | input | 1 | Bus clock, rising edge active |
| HRESETn | input | 1 | Synchronous active-low reset |
| HSEL | input | 1 | Slave select from the address decoder |
| HADDR | input | ADDR_W | Byte address of the transfer |
| HTRANS | input | 2 | Transfer type (idle, pause, first, follow-on) |
| HWRITE | input | 1 | 1 = write, 0 = read |
| HSIZE | input | 3 | Transfer size, log2 of the byte count |
| HWDATA | input | DATA_W | Write data, valid in the data cycle |
| HREADY | input | 1 | System-wide ready fed back from the bus multiplexer |
| HRDATA | output | DATA_W | Read data |
| HREADYOUT | output | 1 | Slave ready; low inserts a stall cycle |
| HRESP | output | 1 | Response, always OKAY (0) |

## Verification
The hardest situation to reach is an address cycle that coincides with a low system ready while this slave is idle. Only another slave stalling the bus can cause it. The bench models that other slave by gating the feedback ready with a bench-controlled enable. It pulls the enable low while presenting a write, in two variants. In one, the write is withdrawn before the enable rises again, and the target word must stay untouched. In the other, the write is held across the stall, and it must land exactly once. Two instances, one with three stall cycles and one with none, run the same pipelined scoreboard traffic. This exercises both the stretched data cycle and overlapped read-after-write to the same word.

// File: rtl/ahbw_pkg.sv
`timescale 1ns/1ps
// Shared encodings for the wait-state memory slave.
// Assumes the standard two-bit transfer-type coding of the bus.
package ahbw_pkg;
    typedef enum logic [1:0] {
        TR_IDLE   = 2'b00,
        TR_BUSY   = 2'b01,
        TR_NONSEQ = 2'b10,
        TR_SEQ    = 2'b11
    } htrans_e;

    localparam logic RESP_OKAY = 1'b0;
endpackage

// File: rtl/ahbw_addr_stage.sv
`timescale 1ns/1ps
// Address-phase capture register.
// Holds the controls of the transfer now in its data phase, so that they
// stay aligned while the bus already shows the next address.
// Assumes xfer_req is already qualified by select and an active transfer type.
module ahbw_addr_stage #(
    parameter int IDX_W = 4,
    parameter int OFS_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             xfer_req,
    input  logic             ready,
    input  logic             write,
    input  logic [2:0]       size,
    input  logic [IDX_W-1:0] idx,
    input  logic [OFS_W-1:0] ofs,
    output logic             accept,
    output logic             pend_valid,
    output logic             pend_write,
    output logic [2:0]       pend_size,
    output logic [IDX_W-1:0] pend_idx,
    output logic [OFS_W-1:0] pend_ofs
);
    // An address phase counts only on an edge where the system is ready.
    assign accept = xfer_req && ready;

    // Capture on acceptance, retire on a ready edge, freeze during a stall.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_valid <= 1'b0;
            pend_write <= 1'b0;
            pend_size  <= '0;
            pend_idx   <= '0;
            pend_ofs   <= '0;
        end else if (accept) begin
            pend_valid <= 1'b1;
            pend_write <= write;
            pend_size  <= size;
            pend_idx   <= idx;
            pend_ofs   <= ofs;
        end else if (ready) begin
            pend_valid <= 1'b0;
        end
    end
endmodule

// File: rtl/ahbw_wait_ctr.sv
`timescale 1ns/1ps
// Stall generator: drives ready low for WAIT_STATES cycles per transfer.
// Assumes accept only occurs on edges where the system ready is high.
module ahbw_wait_ctr #(
    parameter int WAIT_STATES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic accept,
    input  logic pend_valid,
    output logic ready_out
);
    localparam int CNT_W = (WAIT_STATES > 0) ? $clog2(WAIT_STATES + 1) : 1;

    if (WAIT_STATES == 0) begin : g_nowait
        // Zero stalls: always ready, counter logic not built.
        logic unused_ctl;
        assign unused_ctl = ^{clk, rst_n, accept, pend_valid};
        assign ready_out  = 1'b1;
    end else begin : g_wait
        logic [CNT_W-1:0] cnt_q;

        // Load on acceptance, count down while the data phase is stalled.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                cnt_q <= '0;
            end else if (accept) begin
                cnt_q <= CNT_W'(WAIT_STATES);
            end else if (pend_valid && (cnt_q != '0)) begin
                cnt_q <= cnt_q - 1'b1;
            end
        end

        // Stall while a transfer is pending and stalls remain.
        assign ready_out = !(pend_valid && (cnt_q != '0));
    end
endmodule

// File: rtl/ahbw_mem.sv
`timescale 1ns/1ps
// Register-array word store with per-byte write enables.
// Assumes DEPTH is a power of two and DATA_W a multiple of 8.
module ahbw_mem #(
    parameter int DEPTH  = 16,
    parameter int DATA_W = 32
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en,
    input  logic [$clog2(DEPTH)-1:0]   wr_idx,
    input  logic [DATA_W/8-1:0]        wr_mask,
    input  logic [DATA_W-1:0]          wr_data,
    input  logic [$clog2(DEPTH)-1:0]   rd_idx,
    output logic [DATA_W-1:0]          rd_data
);
    localparam int NB = DATA_W / 8;

    logic [DATA_W-1:0] mem_q [DEPTH];

    // Clear on reset, otherwise update the enabled byte lanes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
        end else if (wr_en) begin
            for (int b = 0; b < NB; b++) begin
                if (wr_mask[b]) mem_q[wr_idx][8*b +: 8] <= wr_data[8*b +: 8];
            end
        end
    end

    // Asynchronous read of the addressed word.
    assign rd_data = mem_q[rd_idx];
endmodule

// File: rtl/ahb_wait_mem.sv
`timescale 1ns/1ps
// Bus memory slave with a fixed, programmable number of wait states.
// Captures controls in the address phase, and writes or reads in the data
// phase, which is stretched by WAIT_STATES cycles. New addresses are
// accepted only when the system ready is high.
// Assumes DATA_W >= 16, DEPTH a power of two, and WAIT_STATES in 0..7.
module ahb_wait_mem
    import ahbw_pkg::*;
#(
    parameter int ADDR_W      = 32,
    parameter int DATA_W      = 32,
    parameter int DEPTH       = 16,
    parameter int WAIT_STATES = 2
) (
    input  logic              HCLK,
    input  logic              HRESETn,
    input  logic              HSEL,
    input  logic [ADDR_W-1:0] HADDR,
    input  logic [1:0]        HTRANS,
    input  logic              HWRITE,
    input  logic [2:0]        HSIZE,
    input  logic [DATA_W-1:0] HWDATA,
    input  logic              HREADY,
    output logic [DATA_W-1:0] HRDATA,
    output logic              HREADYOUT,
    output logic              HRESP
);
    localparam int NB    = DATA_W / 8;
    localparam int OFS_W = $clog2(NB);
    localparam int IDX_W = $clog2(DEPTH);

    logic             xfer_req;
    logic             accept;
    logic             pend_valid;
    logic             pend_write;
    logic [2:0]       pend_size;
    logic [IDX_W-1:0] pend_idx;
    logic [OFS_W-1:0] pend_ofs;
    logic [NB-1:0]    lane_mask;
    logic             wr_en;
    logic [DATA_W-1:0] rd_word;
    logic             unused_bits;

    // Active transfer request: selected and of a moving type.
    assign xfer_req = HSEL && ((HTRANS == TR_NONSEQ) || (HTRANS == TR_SEQ));
    assign unused_bits = ^{HADDR[ADDR_W-1:IDX_W+OFS_W]};

    ahbw_addr_stage #(
        .IDX_W (IDX_W),
        .OFS_W (OFS_W)
    ) u_addr (
        .clk        (HCLK),
        .rst_n      (HRESETn),
        .xfer_req   (xfer_req),
        .ready      (HREADY),
        .write      (HWRITE),
        .size       (HSIZE),
        .idx        (HADDR[IDX_W+OFS_W-1:OFS_W]),
        .ofs        (HADDR[OFS_W-1:0]),
        .accept     (accept),
        .pend_valid (pend_valid),
        .pend_write (pend_write),
        .pend_size  (pend_size),
        .pend_idx   (pend_idx),
        .pend_ofs   (pend_ofs)
    );

    ahbw_wait_ctr #(
        .WAIT_STATES (WAIT_STATES)
    ) u_wait (
        .clk        (HCLK),
        .rst_n      (HRESETn),
        .accept     (accept),
        .pend_valid (pend_valid),
        .ready_out  (HREADYOUT)
    );

    // Byte lane b is written when it lies in the same size-aligned group as the offset.
    always_comb begin
        for (int b = 0; b < NB; b++) begin
            lane_mask[b] = (((OFS_W'(b) ^ pend_ofs) >> pend_size) == '0);
        end
    end

    // Commit the write on the ready edge that closes its data phase.
    assign wr_en = pend_valid && pend_write && HREADY;

    ahbw_mem #(
        .DEPTH  (DEPTH),
        .DATA_W (DATA_W)
    ) u_mem (
        .clk     (HCLK),
        .rst_n   (HRESETn),
        .wr_en   (wr_en),
        .wr_idx  (pend_idx),
        .wr_mask (lane_mask),
        .wr_data (HWDATA),
        .rd_idx  (pend_idx),
        .rd_data (rd_word)
    );

    // Drive read data only in a read data phase.
    assign HRDATA = (pend_valid && !pend_write) ? rd_word : '0;
    assign HRESP  = RESP_OKAY;
endmodule

// File: rtl/ahbw_checker.sv
`timescale 1ns/1ps
// Protocol checker for the wait-state memory slave, attached by bind.
module ahbw_checker #(
    parameter int WAIT_STATES = 2,
    parameter int IDX_W       = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             hsel,
    input logic [1:0]       htrans,
    input logic             hready,
    input logic             hreadyout,
    input logic             pend_valid,
    input logic             pend_write,
    input logic [IDX_W-1:0] pend_idx
);
    logic [3:0] low_run;

    // Length of the current run of low ready cycles so far.
    always_ff @(posedge clk) begin
        if (!rst_n)              low_run <= '0;
        else if (!hreadyout)     low_run <= (low_run == 4'hF) ? low_run : low_run + 1'b1;
        else                     low_run <= '0;
    end

    assert_ready_when_empty_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !pend_valid |-> hreadyout);

    assert_idle_no_capture_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (hready && !(hsel && htrans[1])) |=> !pend_valid);

    assert_stall_after_accept_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ((WAIT_STATES != 0) && hsel && htrans[1] && hready) |=> !hreadyout);

    assert_wait_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !hreadyout |-> (32'(low_run) < WAIT_STATES));

    assert_hold_in_stall_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_valid && !hready) |=> (pend_valid && $stable(pend_idx) && $stable(pend_write)));
endmodule

bind ahb_wait_mem ahbw_checker #(
    .WAIT_STATES (WAIT_STATES),
    .IDX_W       (IDX_W)
) u_chk (
    .clk        (HCLK),
    .rst_n      (HRESETn),
    .hsel       (HSEL),
    .htrans     (HTRANS),
    .hready     (HREADY),
    .hreadyout  (HREADYOUT),
    .pend_valid (pend_valid),
    .pend_write (pend_write),
    .pend_idx   (pend_idx)
);

// File: tb/ahbw_harness.sv
`timescale 1ns/1ps
// One slave instance with a pipelined bus master, a reference memory model
// and a scoreboard monitor. WS selects the stall count under test.
module ahbw_harness #(
    parameter int WS = 3
) (
    input logic clk,
    input logic rst_n
);
    logic        hsel = 1'b0;
    logic [31:0] haddr = '0;
    logic [1:0]  htrans = 2'b00;
    logic        hwrite = 1'b0;
    logic [2:0]  hsize = 3'd2;
    logic [31:0] hwdata = '0;
    logic        ext_rdy = 1'b1;
    logic        hready;
    logic [31:0] hrdata;
    logic        hreadyout;
    logic        hresp;

    int    n_tests = 0;
    int    n_fail  = 0;
    logic  done    = 1'b0;
    logic [31:0] model [16];
    logic [31:0] prev_wd = '0;
    logic [31:0] exp_q [$];
    string       tag_q [$];

    // Feedback ready: this slave combined with a modelled neighbour slave.
    assign hready = hreadyout & ext_rdy;

    ahb_wait_mem #(.WAIT_STATES(WS)) i_ahb_wait_mem (
        .HCLK(clk), .HRESETn(rst_n), .HSEL(hsel), .HADDR(haddr), .HTRANS(htrans),
        .HWRITE(hwrite), .HSIZE(hsize), .HWDATA(hwdata), .HREADY(hready),
        .HRDATA(hrdata), .HREADYOUT(hreadyout), .HRESP(hresp)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] got, input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s ws=%0d %s: got %h expected %h", req, WS, what, got, exp);
        end
    endtask

    // Reference write: lanes from an aligned base of 2**size bytes.
    task automatic model_write(input logic [31:0] a, input logic [2:0] sz, input logic [31:0] d);
        int nbytes = 1 << sz;
        int base;
        if (nbytes > 4) nbytes = 4;
        base = int'(a[1:0]) - (int'(a[1:0]) % nbytes);
        for (int b = 0; b < 4; b++)
            if (b >= base && b < base + nbytes) model[a[5:2]][8*b +: 8] = d[8*b +: 8];
    endtask

    // One address phase; returns after the edge on which it was taken.
    task automatic phase(input logic sel, input logic [1:0] tr, input logic w,
                         input logic [31:0] a, input logic [2:0] sz,
                         input logic [31:0] d, input string tag);
        logic r;
        @(negedge clk);
        hsel = sel; htrans = tr; hwrite = w; haddr = a; hsize = sz; hwdata = prev_wd;
        forever begin
            #1 r = hready;
            @(posedge clk);
            if (r) break;
            @(negedge clk);
        end
        if (sel && tr[1]) begin
            if (w) model_write(a, sz, d);
            else begin exp_q.push_back(model[a[5:2]]); tag_q.push_back(tag); end
        end
        prev_wd = d;
    endtask

    task automatic wr(input logic [31:0] a, input logic [2:0] sz, input logic [31:0] d);
        phase(1'b1, 2'b10, 1'b1, a, sz, d, "");
    endtask

    task automatic rd(input logic [31:0] a, input string tag);
        phase(1'b1, 2'b10, 1'b0, a, 3'd2, 32'h0, tag);
    endtask

    task automatic idle();
        phase(1'b0, 2'b00, 1'b0, 32'h0, 3'd2, 32'h0, "");
    endtask

    // Monitor: samples before each edge and scores completed data phases.
    logic mon_pend = 1'b0;
    logic mon_w    = 1'b0;
    int   low_cnt  = 0;
    initial begin
        forever begin
            @(negedge clk);
            #1;
            if (rst_n) begin
                check(hresp == 1'b0, "R8", "response", {31'b0, hresp}, 32'h0);
                if (!mon_pend) check(hreadyout == 1'b1, "R1", "ready with nothing pending",
                                     {31'b0, hreadyout}, 32'h1);
                if (!mon_pend || mon_w) check(hrdata == 32'h0, "R4", "idle read data", hrdata, 32'h0);
                if (mon_pend) begin
                    if (!hreadyout) low_cnt++;
                    if (hready) begin
                        check(low_cnt == WS, (WS == 0) ? "R6" : "R5", "stall cycles",
                              32'(low_cnt), 32'(WS));
                        if (!mon_w) begin
                            if (exp_q.size() == 0) check(1'b0, "R4", "unexpected read", hrdata, 32'h0);
                            else begin
                                automatic logic [31:0] e = exp_q.pop_front();
                                automatic string t = tag_q.pop_front();
                                check(hrdata == e, t, "read data", hrdata, e);
                            end
                        end
                        mon_pend = 1'b0;
                    end
                end
                if (hsel && htrans[1] && hready) begin
                    mon_pend = 1'b1; mon_w = hwrite; low_cnt = 0;
                end
            end
        end
    end

    // Stimulus sequence.
    initial begin
        for (int i = 0; i < 16; i++) model[i] = '0;
        @(posedge rst_n);
        @(negedge clk); #1;
        check(hreadyout == 1'b1, "R1", "reset ready", {31'b0, hreadyout}, 32'h1);
        check(hrdata == 32'h0, "R1", "reset read data", hrdata, 32'h0);
        rd(32'h0C, "R1");
        // Word writes then pipelined reads.
        wr(32'h04, 3'd2, 32'h1122_3344);
        wr(32'h08, 3'd2, 32'hA5A5_5A5A);
        rd(32'h04, "R3");
        rd(32'h08, "R3");
        // Read immediately after a write to the same word.
        wr(32'h0C, 3'd2, 32'h0BAD_F00D);
        rd(32'h0C, "R6");
        // Narrow writes into one word.
        wr(32'h10, 3'd2, 32'hFFFF_FFFF);
        wr(32'h11, 3'd0, 32'h0000_AB00);
        wr(32'h12, 3'd1, 32'h1234_0000);
        rd(32'h10, "R7");
        wr(32'h14, 3'd0, 32'h0000_0077);
        wr(32'h16, 3'd0, 32'h0099_0000);
        rd(32'h14, "R7");
        // Ignored address phases: unselected, idle and pause types.
        phase(1'b0, 2'b10, 1'b1, 32'h18, 3'd2, 32'hDEAD_0001, "");
        phase(1'b1, 2'b00, 1'b1, 32'h18, 3'd2, 32'hDEAD_0002, "");
        phase(1'b1, 2'b01, 1'b1, 32'h18, 3'd2, 32'hDEAD_0003, "");
        rd(32'h18, "R2");
        // Follow-on transfer type is accepted.
        phase(1'b1, 2'b11, 1'b1, 32'h1C, 3'd2, 32'h5E05_0007, "");
        rd(32'h1C, "R2");
        // Write shown only during a neighbour stall, then withdrawn.
        idle();
        @(negedge clk);
        ext_rdy = 1'b0;
        hsel = 1'b1; htrans = 2'b10; hwrite = 1'b1; haddr = 32'h20; hwdata = 32'hBEEF_0008;
        repeat (2) @(negedge clk);
        #1 check(hreadyout == 1'b1, "R9", "no capture during stall", {31'b0, hreadyout}, 32'h1);
        @(negedge clk);
        hsel = 1'b0; htrans = 2'b00;
        @(negedge clk);
        ext_rdy = 1'b1;
        #1 check(hreadyout == 1'b1, "R9", "still idle after stall", {31'b0, hreadyout}, 32'h1);
        rd(32'h20, "R9");
        // Write held across a neighbour stall lands once.
        idle();
        @(negedge clk);
        ext_rdy = 1'b0;
        fork
            begin repeat (2) @(negedge clk); ext_rdy = 1'b1; end
        join_none
        wr(32'h24, 3'd2, 32'hCAFE_0009);
        rd(32'h24, "R9");
        // Sweep all words back to back.
        for (int i = 0; i < 16; i++) wr(32'(i * 4), 3'd2, 32'h3C00_0000 + 32'(i * 257));
        for (int i = 0; i < 16; i++) rd(32'(i * 4), "R3");
        repeat (3) idle();
        check(exp_q.size() == 0, "R4", "reads left unscored", 32'(exp_q.size()), 32'h0);
        done = 1'b1;
    end
endmodule

// File: tb/test_ahb_wait_mem.sv
`timescale 1ns/1ps
// Top bench: runs a stalling and a zero-stall slave and reports the totals.
module test_ahb_wait_mem;
    logic clk   = 1'b0;
    logic rst_n = 1'b0;
    int   tests;
    int   fails;

    always #2 clk = ~clk;

    ahbw_harness #(.WS(3)) u_ws3 (.clk(clk), .rst_n(rst_n));
    ahbw_harness #(.WS(0)) u_ws0 (.clk(clk), .rst_n(rst_n));

    initial begin
        bit timed_out = 1'b0;
        repeat (5) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        fork
            begin : wait_done
                wait (u_ws3.done && u_ws0.done);
            end
            begin : watchdog
                repeat (50000) @(posedge clk);
                timed_out = 1'b1;
            end
        join_any
        disable fork;
        tests = u_ws3.n_tests + u_ws0.n_tests;
        fails = u_ws3.n_fail + u_ws0.n_fail;
        if (timed_out) begin
            tests++;
            fails++;
            $display("FAIL R5 watchdog: done got 0 expected 1");
        end
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule